// File: doc/BRIEF.md
# Multi-Mode Serial Character Transmitter

This block turns bytes written by a host into a serial bit stream. The host places a character in a one-byte holding register. At each character boundary the transmitter moves the held character, or a piece of framing it generates itself, into a 20-bit shift register. It then clocks that register out one bit for each pulse of a bit-clock enable. A configuration word selects one of four framings. Asynchronous characters carry start, parity and stop bits. Monosync and bisync messages open with one or two programmed sync characters and close with a CRC. Bit-oriented frames are bounded by a flag pattern, carry an inverted CCITT CRC and apply zero insertion to the data and CRC fields.

A host waits for the buffer-empty flag, writes the next character and holds the end-of-message input high once it has nothing more to send. When the buffer is empty at a character boundary and that input is set, the transmitter closes the message. Character length is 5 to 8 bits. Characters are right-justified, and every bit above the selected length is masked.

Top module: `serialTx`

## Requirements
- R1: After reset the serial output is 1 and the buffer-empty flag is 1.
- R2: A host write stores the byte and clears the buffer-empty flag on the next clock. The flag sets when the held character moves into the shift register. If a write and that move fall in the same clock, the write wins: the old byte is sent and the flag stays clear.
- R3: The serial output changes only in the clock after a bit-clock enable pulse, and by exactly one bit per pulse. Bits go out least significant first.
- R4: modeSel 2'b00 is asynchronous. Each character is sent as a 0 start bit, then lenSel+5 data bits (lenSel 0..3 gives 5..8 bits), then an optional parity bit, then one stop bit, or two when stopTwo is 1. With nothing to send the line rests at 1.
- R5: With parityOn set, the parity bit makes the count of ones in data plus parity even when parityOdd is 0, and odd when parityOdd is 1.
- R6: Buffer bits at or above the selected character length have no effect on the line or on the CRC.
- R7: modeSel 2'b01 (monosync) opens a message with the 8-bit syncFirst character, followed by data characters of the selected length and no parity.
- R8: modeSel 2'b10 (bisync) opens a message with syncFirst followed by syncSecond.
- R9: In either byte-sync mode, when the buffer is empty at a boundary inside a message and endOfMsg is 0, the opening sync character(s) are sent again as fill. Fill is left out of the CRC.
- R10: In byte-sync modes, an empty buffer at a boundary with endOfMsg set sends 16 CRC bits, least significant first. The CRC is the reflected x^16+x^15+x^2+1 CRC (constant 16'hA001), preset to 0, computed over the data bits only and sent uninverted. One idle 1 bit follows.
- R11: modeSel 2'b11 (bit-oriented) opens and closes each frame with flag 8'h7E. Before the closing flag it sends the one's complement of a reflected CCITT CRC (constant 16'h8408, preset 16'hFFFF) taken over the data bits.
- R12: In bit-oriented mode a 0 is inserted after every five consecutive 1s in the data and CRC fields. It is never inserted within flags, and the inserted bit does not enter the CRC.
- R13: In bit-oriented mode, an empty buffer at a boundary inside a frame with endOfMsg 0 sends idle 1 bits that do not count toward zero insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWr | input | 1 | Host write strobe for the transmit buffer |
| hostData | input | 8 | Character written by the host, right-justified |
| modeSel | input | 2 | Framing: 00 async, 01 monosync, 10 bisync, 11 bit-oriented |
| lenSel | input | 2 | Character length minus 5 |
| parityOn | input | 1 | Append a parity bit in asynchronous mode |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| stopTwo | input | 1 | Two stop bits when 1 |
| syncFirst | input | 8 | First (or only) sync character |
| syncSecond | input | 8 | Second sync character for bisync |
| endOfMsg | input | 1 | Close the message when the buffer runs empty |
| bitTick | input | 1 | Bit-clock enable, one bit per pulse |
| txOut | output | 1 | Serial data |
| bufEmpty | output | 1 | Transmit buffer is free for a new character |

## Verification
Most faults in the shift register, bit counter or framing sequencer show up on txOut at the next bit-clock pulse, as a shifted, missing or extra bit. A wrong holding flag shows up on bufEmpty within one clock of the write or load that should have changed it. A corrupted CRC register or zero-insertion counter stays hidden until the message closes, and then shows as a wrong CRC bit or a misplaced stuffed zero, up to a whole message later. For this reason the model compares both outputs on every clock, not only at message ends.

// File: rtl/txPkg.sv
package txPkg;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'b00,
    MODE_MONO   = 2'b01,
    MODE_BISYNC = 2'b10,
    MODE_FRAMED = 2'b11
  } txMode_e;

  typedef enum logic [2:0] {
    LD_NONE,
    LD_DATA,
    LD_SYNC1,
    LD_SYNC2,
    LD_FLAG,
    LD_CRC
  } loadKind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_MSG,
    PH_TAIL
  } msgPhase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic      step;
    loadKind_e load;
    logic      crcClear;
  } txStrobe_t;

endpackage

// File: rtl/txControl.sv
module txControl
  import txPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  txMode_e    modeNow,
  input  logic       endOfMsg,
  input  logic       bitTick,
  input  logic       atBoundary,
  input  logic       bufFull,
  output txStrobe_t  strobe
);

  msgPhase_e phase, phaseNext;

  always_comb begin
    strobe.step     = bitTick;
    strobe.load     = LD_NONE;
    strobe.crcClear = 1'b0;
    phaseNext       = phase;
    if (bitTick && atBoundary) begin
      case (phase)
        PH_IDLE: begin
          if (bufFull) begin
            case (modeNow)
              MODE_ASYNC: strobe.load = LD_DATA;
              MODE_MONO: begin
                strobe.load     = LD_SYNC1;
                strobe.crcClear = 1'b1;
                phaseNext       = PH_MSG;
              end
              MODE_BISYNC: begin
                strobe.load     = LD_SYNC2;
                strobe.crcClear = 1'b1;
                phaseNext       = PH_MSG;
              end
              default: begin
                strobe.load     = LD_FLAG;
                strobe.crcClear = 1'b1;
                phaseNext       = PH_MSG;
              end
            endcase
          end
        end
        PH_MSG: begin
          if (bufFull) begin
            strobe.load = LD_DATA;
          end else if (endOfMsg) begin
            strobe.load = LD_CRC;
            phaseNext   = PH_TAIL;
          end else begin
            case (modeNow)
              MODE_MONO:   strobe.load = LD_SYNC1;
              MODE_BISYNC: strobe.load = LD_SYNC2;
              default:     strobe.load = LD_NONE;
            endcase
          end
        end
        default: begin
          strobe.load = (modeNow == MODE_FRAMED) ? LD_FLAG : LD_NONE;
          phaseNext   = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/txDatapath.sv
module txDatapath
  import txPkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter int              SHIFT_W      = 20,
  parameter int              CRC_W        = 16,
  parameter logic [DATA_W-1:0] FLAG_PATTERN = 8'h7E,
  parameter logic [CRC_W-1:0]  SYNC_POLY    = 16'hA001,
  parameter logic [CRC_W-1:0]  FRAME_POLY   = 16'h8408,
  parameter int              RUN_LIMIT    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostData,
  input  txMode_e           modeNow,
  input  logic [1:0]        lenSel,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              stopTwo,
  input  logic [DATA_W-1:0] syncFirst,
  input  logic [DATA_W-1:0] syncSecond,
  input  txStrobe_t         strobe,
  output logic              atBoundary,
  output logic              bufFull,
  output logic              txOut,
  output logic              bufEmpty
);

  localparam int CNT_W = $clog2(SHIFT_W + 1);
  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam logic [CRC_W-1:0] FRAME_PRESET = '1;
  localparam logic [CRC_W-1:0] SYNC_PRESET  = '0;

  logic [DATA_W-1:0]  holdReg;
  logic               holdFull;
  logic [SHIFT_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitsLeft;
  loadKind_e          unitKind;
  logic [RUN_W-1:0]   onesRun;
  logic [CRC_W-1:0]   crcReg;
  logic               txReg;

  logic [CNT_W-1:0]   charBits;
  logic [DATA_W-1:0]  maskedData;
  logic               parityBit;
  logic [SHIFT_W-1:0] asyncWord;
  logic [CNT_W-1:0]   asyncLen;
  logic [SHIFT_W-1:0] loadWord;
  logic [CNT_W-1:0]   loadLen;
  logic [CRC_W-1:0]   crcOut;
  logic [CRC_W-1:0]   crcNext;
  logic [CRC_W-1:0]   activePoly;
  logic [CRC_W-1:0]   activePreset;
  logic               stuffDue;
  logic               emitBit;
  loadKind_e          emitKind;
  logic               emitCrc;
  logic               emitStuffable;
  logic               crcFb;

  assign charBits = CNT_W'(DATA_W - 3) + CNT_W'(lenSel);
  assign stuffDue = (onesRun == RUN_W'(RUN_LIMIT));
  assign atBoundary = (bitsLeft == '0) && !stuffDue;

  // character masking and parity
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      maskedData[i] = holdReg[i] && (i < int'(charBits));
    end
  end
  assign parityBit = (^maskedData) ^ parityOdd;

  // asynchronous frame assembly: start, data, parity, stop
  always_comb begin
    asyncWord    = '1;
    asyncWord[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(charBits)) asyncWord[1 + i] = maskedData[i];
    end
    for (int i = 0; i <= DATA_W; i++) begin
      if (parityOn && (i == int'(charBits))) asyncWord[1 + i] = parityBit;
    end
  end
  assign asyncLen = CNT_W'(2) + charBits + CNT_W'(parityOn) + CNT_W'(stopTwo);

  // CRC selection
  generate
    if (CRC_W > 0) begin : g_crcSel
      assign activePoly   = (modeNow == MODE_FRAMED) ? FRAME_POLY : SYNC_POLY;
      assign activePreset = (modeNow == MODE_FRAMED) ? FRAME_PRESET : SYNC_PRESET;
      assign crcOut       = (modeNow == MODE_FRAMED) ? ~crcReg : crcReg;
    end
  endgenerate

  // unit selection for a load
  always_comb begin
    loadWord = '1;
    loadLen  = CNT_W'(1);
    case (strobe.load)
      LD_DATA: begin
        if (modeNow == MODE_ASYNC) begin
          loadWord = asyncWord;
          loadLen  = asyncLen;
        end else begin
          loadWord = SHIFT_W'(maskedData);
          loadLen  = charBits;
        end
      end
      LD_SYNC1: begin
        loadWord = SHIFT_W'(syncFirst);
        loadLen  = CNT_W'(DATA_W);
      end
      LD_SYNC2: begin
        loadWord = SHIFT_W'({syncSecond, syncFirst});
        loadLen  = CNT_W'(2 * DATA_W);
      end
      LD_FLAG: begin
        loadWord = SHIFT_W'(FLAG_PATTERN);
        loadLen  = CNT_W'(DATA_W);
      end
      LD_CRC: begin
        loadWord = SHIFT_W'(crcOut);
        loadLen  = CNT_W'(CRC_W);
      end
      default: begin
        loadWord = '1;
        loadLen  = CNT_W'(1);
      end
    endcase
  end

  // the bit leaving on this tick and its attributes
  always_comb begin
    if (stuffDue) begin
      emitBit  = 1'b0;
      emitKind = LD_NONE;
    end else if (bitsLeft != '0) begin
      emitBit  = shiftReg[0];
      emitKind = unitKind;
    end else begin
      emitBit  = loadWord[0];
      emitKind = strobe.load;
    end
    emitCrc       = (emitKind == LD_DATA) && (modeNow != MODE_ASYNC);
    emitStuffable = (modeNow == MODE_FRAMED) &&
                    ((emitKind == LD_DATA) || (emitKind == LD_CRC));
    crcFb         = crcReg[0] ^ emitBit;
    crcNext       = (crcReg >> 1) ^ (crcFb ? activePoly : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= 1'b1;
      shiftReg <= '1;
      bitsLeft <= '0;
      unitKind <= LD_NONE;
      onesRun  <= '0;
      crcReg   <= '0;
    end else if (strobe.step) begin
      txReg <= emitBit;
      if (stuffDue) begin
        onesRun <= '0;
      end else begin
        onesRun <= (emitStuffable && emitBit) ? onesRun + RUN_W'(1) : '0;
        if (bitsLeft != '0) begin
          shiftReg <= shiftReg >> 1;
          bitsLeft <= bitsLeft - CNT_W'(1);
        end else begin
          shiftReg <= loadWord >> 1;
          bitsLeft <= loadLen - CNT_W'(1);
          unitKind <= strobe.load;
        end
      end
      if (strobe.crcClear)  crcReg <= activePreset;
      else if (emitCrc)     crcReg <= crcNext;
    end
  end

  // holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (hostWr) begin
      holdReg  <= hostData;
      holdFull <= 1'b1;
    end else if (strobe.step && atBoundary && (strobe.load == LD_DATA)) begin
      holdFull <= 1'b0;
    end
  end

  assign bufFull  = holdFull;
  assign bufEmpty = !holdFull;
  assign txOut    = txReg;

endmodule

// File: rtl/serialTx.sv
module serialTx
  import txPkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                SHIFT_W      = 20,
  parameter int                CRC_W        = 16,
  parameter logic [DATA_W-1:0] FLAG_PATTERN = 8'h7E,
  parameter logic [CRC_W-1:0]  SYNC_POLY    = 16'hA001,
  parameter logic [CRC_W-1:0]  FRAME_POLY   = 16'h8408,
  parameter int                RUN_LIMIT    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostData,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        lenSel,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              stopTwo,
  input  logic [DATA_W-1:0] syncFirst,
  input  logic [DATA_W-1:0] syncSecond,
  input  logic              endOfMsg,
  input  logic              bitTick,
  output logic              txOut,
  output logic              bufEmpty
);

  txMode_e   modeNow;
  txStrobe_t strobeBus;
  logic      atBoundary;
  logic      bufFullSig;

  assign modeNow = txMode_e'(modeSel);

  txControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeNow    (modeNow),
    .endOfMsg   (endOfMsg),
    .bitTick    (bitTick),
    .atBoundary (atBoundary),
    .bufFull    (bufFullSig),
    .strobe     (strobeBus)
  );

  txDatapath #(
    .DATA_W       (DATA_W),
    .SHIFT_W      (SHIFT_W),
    .CRC_W        (CRC_W),
    .FLAG_PATTERN (FLAG_PATTERN),
    .SYNC_POLY    (SYNC_POLY),
    .FRAME_POLY   (FRAME_POLY),
    .RUN_LIMIT    (RUN_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostWr     (hostWr),
    .hostData   (hostData),
    .modeNow    (modeNow),
    .lenSel     (lenSel),
    .parityOn   (parityOn),
    .parityOdd  (parityOdd),
    .stopTwo    (stopTwo),
    .syncFirst  (syncFirst),
    .syncSecond (syncSecond),
    .strobe     (strobeBus),
    .atBoundary (atBoundary),
    .bufFull    (bufFullSig),
    .txOut      (txOut),
    .bufEmpty   (bufEmpty)
  );

endmodule

// File: rtl/txChecker.sv
module txChecker
  import txPkg::*;
#(
  parameter logic FLAG_LSB = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostWr,
  input logic       bitTick,
  input logic [1:0] modeSel,
  input logic       txOut,
  input logic       bufEmpty,
  input txStrobe_t  strobe,
  input logic       atBoundary,
  input logic       bufFull
);

  // R2: a write clears the empty flag
  p_wr_clears_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> !bufEmpty);

  // R2: the empty flag only rises after a data load without a write
  p_empty_rise_on_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> $past(strobe.load == LD_DATA && !hostWr));

  // R2: a data load needs a held character
  p_load_needs_data_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load == LD_DATA) |-> bufFull);

  // R3: the line holds between bit-clock pulses
  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txOut));

  // R3: loads happen only at a boundary on a pulse
  p_load_on_boundary_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load != LD_NONE) |-> (bitTick && atBoundary));

  // R4: an asynchronous character begins with a 0 start bit
  p_start_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load == LD_DATA && modeSel == 2'b00) |=> !txOut);

  // R11: a flag begins with its least significant bit
  p_flag_first_bit_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load == LD_FLAG) |=> (txOut == FLAG_LSB));

endmodule

bind serialTx txChecker #(.FLAG_LSB(FLAG_PATTERN[0])) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWr     (hostWr),
  .bitTick    (bitTick),
  .modeSel    (modeSel),
  .txOut      (txOut),
  .bufEmpty   (bufEmpty),
  .strobe     (strobeBus),
  .atBoundary (atBoundary),
  .bufFull    (bufFullSig)
);

// File: tb/sim_serialTx.sv
`timescale 1ns/1ps
module sim_serialTx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic [1:0] modeSel = 2'b00;
  logic [1:0] lenSel = 2'b11;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       stopTwo = 1'b0;
  logic [7:0] syncFirst = 8'h16;
  logic [7:0] syncSecond = 8'h32;
  logic       endOfMsg = 1'b1;
  logic       bitTick = 1'b0;
  logic       txOut;
  logic       bufEmpty;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    cmpOn = 1'b0;
  bit    runDone = 1'b0;

  always #4 clk = ~clk;

  serialTx u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostData(hostData),
    .modeSel(modeSel), .lenSel(lenSel), .parityOn(parityOn),
    .parityOdd(parityOdd), .stopTwo(stopTwo), .syncFirst(syncFirst),
    .syncSecond(syncSecond), .endOfMsg(endOfMsg), .bitTick(bitTick),
    .txOut(txOut), .bufEmpty(bufEmpty)
  );

  // ---------------- behavioural reference model ----------------
  // queue entry: bit0 value, bit1 enters CRC, bit2 subject to zero insertion
  int   q[$];
  int   mCrc;
  int   mOnes;
  bit   mPend;
  int   mPhase;       // 0 idle, 1 in message, 2 CRC sent
  bit   mFull;
  int   mBuf;
  bit   mTx;

  task automatic pushBits(int val, int len, int attr);
    for (int i = 0; i < len; i++) q.push_back(((val >> i) & 1) | attr);
  endtask

  task automatic pushChar();
    int n;
    int d;
    int ones;
    n = 5 + int'(lenSel);
    d = mBuf & ((1 << n) - 1);
    mFull = 1'b0;
    if (modeSel == 2'b00) begin
      pushBits(0, 1, 0);
      pushBits(d, n, 0);
      if (parityOn) begin
        ones = $countones(d);
        pushBits((ones + int'(parityOdd)) & 1, 1, 0);
      end
      pushBits(1, 1, 0);
      if (stopTwo) pushBits(1, 1, 0);
    end else begin
      pushBits(d, n, 2 | ((modeSel == 2'b11) ? 4 : 0));
    end
  endtask

  task automatic pushSync();
    if (modeSel == 2'b01) pushBits(syncFirst, 8, 0);
    else pushBits({syncSecond, syncFirst}, 16, 0);
  endtask

  task automatic decide();
    case (mPhase)
      0: begin
        if (mFull) begin
          if (modeSel == 2'b00) pushChar();
          else if (modeSel == 2'b11) begin
            pushBits(8'h7E, 8, 0); mCrc = 16'hFFFF; mPhase = 1;
          end else begin
            pushSync(); mCrc = 0; mPhase = 1;
          end
        end else pushBits(1, 1, 0);
      end
      1: begin
        if (mFull) pushChar();
        else if (endOfMsg) begin
          if (modeSel == 2'b11) pushBits((~mCrc) & 16'hFFFF, 16, 4);
          else pushBits(mCrc, 16, 0);
          mPhase = 2;
        end else if (modeSel == 2'b11) pushBits(1, 1, 0);
        else pushSync();
      end
      default: begin
        if (modeSel == 2'b11) pushBits(8'h7E, 8, 0);
        else pushBits(1, 1, 0);
        mPhase = 0;
      end
    endcase
  endtask

  always @(posedge clk) begin : model
    bit wr;
    int wd;
    int e;
    int fb;
    wr = hostWr;
    wd = hostData;
    if (!rstN) begin
      q.delete(); mCrc = 0; mOnes = 0; mPend = 0; mPhase = 0;
      mFull = 0; mBuf = 0; mTx = 1;
    end else begin
      if (bitTick) begin
        if (mPend) begin
          mTx = 0; mOnes = 0; mPend = 0;
        end else begin
          if (q.size() == 0) decide();
          e = q.pop_front();
          mTx = e[0];
          if (e[1]) begin
            fb = (mCrc ^ e) & 1;
            mCrc = mCrc >> 1;
            if (fb != 0) mCrc = mCrc ^ ((modeSel == 2'b11) ? 16'h8408 : 16'hA001);
          end
          if (e[2]) begin
            mOnes = e[0] ? mOnes + 1 : 0;
            if (mOnes == 5) mPend = 1;
          end else mOnes = 0;
        end
      end
      if (wr) begin mBuf = wd; mFull = 1; end
    end
  end

  // ---------------- per-clock comparison ----------------
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && cmpOn && !runDone) begin
        checks++;
        if (txOut !== mTx) begin
          failures++;
          $display("FAIL %s txOut actual=%0b expected=%0b t=%0t", curReq, txOut, mTx, $time);
        end
        checks++;
        if (bufEmpty !== !mFull) begin
          failures++;
          $display("FAIL %s bufEmpty actual=%0b expected=%0b t=%0t", curReq, bufEmpty, !mFull, $time);
        end
      end
    end
  end

  // bit-clock enable: one pulse every third clock
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % 3;
      bitTick = (cnt == 0) && rstN;
    end
  end

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic writeChar(logic [7:0] v);
    @(negedge clk);
    while (!bufEmpty) @(negedge clk);
    hostWr = 1'b1;
    hostData = v;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!runDone) begin
      runDone = 1'b1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    settle(4);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check1("R1 txOut", txOut, 1'b1);
    check1("R1 bufEmpty", bufEmpty, 1'b1);
    cmpOn = 1'b1;

    // R2 R3 R4: async 8 data bits, no parity, one stop
    curReq = "R2 R3 R4 async";
    modeSel = 2'b00; lenSel = 2'b11; parityOn = 0; stopTwo = 0;
    writeChar(8'hA5);
    check1("R2 empty cleared by write", bufEmpty, 1'b0);
    writeChar(8'h3C);
    writeChar(8'h00);
    writeChar(8'hFF);
    settle(150);

    // R5 R6: 7-bit even parity two stops, upper bit set
    curReq = "R5 R6 async parity";
    lenSel = 2'b10; parityOn = 1; parityOdd = 0; stopTwo = 1;
    writeChar(8'hD3);
    writeChar(8'h81);
    // R5 R6: 5-bit odd parity, upper bits set
    lenSel = 2'b00; parityOdd = 1; stopTwo = 0;
    writeChar(8'hEA);
    writeChar(8'h1F);
    lenSel = 2'b01;
    writeChar(8'hC7);
    settle(150);

    // R7 R9 R10: monosync with fill, then CRC
    curReq = "R7 R9 R10 mono";
    modeSel = 2'b01; lenSel = 2'b11; parityOn = 0; endOfMsg = 0;
    writeChar(8'h41);
    writeChar(8'h9C);
    settle(90);
    writeChar(8'hF0);
    endOfMsg = 1;
    settle(250);
    // a short-length message in monosync (R6 masking into the CRC)
    curReq = "R6 R10 mono 6-bit";
    lenSel = 2'b01;
    writeChar(8'hFF);
    writeChar(8'h95);
    settle(250);

    // R8 R9 R10: bisync
    curReq = "R8 R9 R10 bisync";
    modeSel = 2'b10; lenSel = 2'b11; endOfMsg = 0;
    writeChar(8'h12);
    settle(120);
    writeChar(8'hC8);
    endOfMsg = 1;
    settle(250);

    // R11 R12 R13: bit-oriented frames with long runs of ones
    curReq = "R11 R12 R13 framed";
    modeSel = 2'b11; lenSel = 2'b11; endOfMsg = 0;
    writeChar(8'hFF);
    writeChar(8'h7E);
    settle(60);
    writeChar(8'h1F);
    writeChar(8'hF8);
    endOfMsg = 1;
    settle(300);
    curReq = "R12 framed 7-bit";
    lenSel = 2'b10;
    writeChar(8'hFF);
    writeChar(8'h3F);
    settle(300);

    // R2: write coinciding with loads, back-to-back in async
    curReq = "R2 back-to-back";
    modeSel = 2'b00; lenSel = 2'b11;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      hostWr = 1'b1;
      hostData = 8'(8'h11 * k + 8'h05);
    end
    @(negedge clk);
    hostWr = 1'b0;
    settle(200);
    check1("R4 line idles at 1", txOut, 1'b1);
    check1("R2 buffer drained", bufEmpty, 1'b1);

    runDone = 1'b1;
    finishRun();
  end

endmodule